// File: doc/BRIEF.md
# Multithreaded Issue Slot Allocator

This block decides, every cycle, which hardware threads fill a fixed set of issue slots. Each thread offers a request: a valid flag, a stall flag raised while it waits on a cache miss, and a count of instructions ready to issue. The block answers within the same cycle. For each slot it returns a valid bit, the thread that owns the slot, and the position of that instruction within the thread's ready group. For each thread it returns a ready bit that shows the thread was granted at least one slot. It also returns the number of slots in use.

Two policies are available. In simultaneous mode, any mix of threads may share the slots in one cycle. In fine-grained mode, a single thread takes every slot issued in that cycle. A rotating start pointer spreads service evenly across threads. An optional priority thread is served ahead of the rotation, which limits its slowdown when other threads compete with it. Decoding, renaming and execution are handled elsewhere.

Top module: `smt_slot_alloc`

## Requirements
- R1: No more than NUM_SLOTS slots are valid in a cycle, and `used_cnt_o` equals the number of valid slots.
- R2: Valid slots always start at slot 0 and have no gaps. An idle slot drives thread id 0 and index 0.
- R3: A thread whose valid bit is low, or whose stall bit is high, is given no slot. Those slots go to other threads.
- R4: In simultaneous mode, threads are visited in service order. Each thread takes the smaller of its ready count and the slots still free. Its instructions land in consecutive slots with indices 0, 1, 2 and so on.
- R5: In simultaneous mode with `prio_en_i` high, the thread named by `prio_tid_i` is visited first. The other threads follow in rotation from the pointer, and the priority thread is skipped in that rotation.
- R6: The rotation pointer is 0 after reset and advances by one, modulo NUM_THREADS, on every clock edge. The rotation order starts at the pointer's thread.
- R7: In fine-grained mode, only the first thread in service order with a non-zero effective count issues. It takes the smaller of that count and NUM_SLOTS.
- R8: In fine-grained mode with `prio_en_i` high, the priority thread is chosen whenever its effective count is non-zero.
- R9: A ready count above NUM_SLOTS is treated as NUM_SLOTS.
- R10: `thread_rdy_o[t]` is high exactly when thread t holds at least one valid slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 0 = simultaneous, 1 = fine-grained |
| prio_en_i | input | 1 | Enable the priority thread |
| prio_tid_i | input | TID_W | Priority thread id |
| req_valid_i | input | NUM_THREADS | Per-thread request valid |
| req_stall_i | input | NUM_THREADS | Per-thread stall (cache miss) |
| req_cnt_i | input | NUM_THREADS x CNT_W | Per-thread ready instruction count |
| slot_vld_o | output | NUM_SLOTS | Slot carries an instruction |
| slot_tid_o | output | NUM_SLOTS x TID_W | Owning thread per slot |
| slot_idx_o | output | NUM_SLOTS x IDX_W | Instruction index within its thread |
| used_cnt_o | output | CNT_W | Number of valid slots |
| thread_rdy_o | output | NUM_THREADS | Thread received at least one slot |

## Verification
The bench builds the block with four threads and four slots. The count field is three bits wide, so counts from 5 to 7 can be driven and the clamping rule is exercised. With four threads, the pointer completes a full turn every four cycles. This means every start position, with and without a priority thread, is reached many times during a few hundred random cycles. Those cycles also mix both modes, stalls and dropped valid bits, so oversubscribed and partly filled cycles both appear often.

// File: rtl/smt_alloc_pkg.sv
package smt_alloc_pkg;
  typedef enum logic {
    MODE_SMT  = 1'b0,
    MODE_FGMT = 1'b1
  } issue_mode_e;
endpackage

// File: rtl/smt_rr_ptr.sv
module smt_rr_ptr #(
  parameter int N_THR = 4,
  localparam int TID_W = $clog2(N_THR)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [TID_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ptr_o <= '0;
    else if (ptr_o == TID_W'(N_THR - 1)) ptr_o <= '0;
    else                                  ptr_o <= ptr_o + 1'b1;
  end
endmodule

// File: rtl/smt_thread_order.sv
module smt_thread_order #(
  parameter int N_THR = 4,
  localparam int TID_W = $clog2(N_THR)
) (
  input  logic [TID_W-1:0]            ptr_i,
  input  logic                        prio_en_i,
  input  logic [TID_W-1:0]            prio_tid_i,
  output logic [N_THR-1:0][TID_W-1:0] ord_o
);
  always_comb begin
    int pos;
    int t;
    pos   = 0;
    ord_o = '0;
    if (prio_en_i) begin
      ord_o[0] = prio_tid_i;
      pos      = 1;
    end
    for (int j = 0; j < N_THR; j++) begin
      t = (int'(ptr_i) + j) % N_THR;
      // priority thread already placed at the head
      if (!(prio_en_i && (t == int'(prio_tid_i))) && (pos < N_THR)) begin
        ord_o[pos] = TID_W'(t);
        pos        = pos + 1;
      end
    end
  end
endmodule

// File: rtl/smt_slot_fill.sv
module smt_slot_fill #(
  parameter int N_THR  = 4,
  parameter int N_SLOT = 4,
  localparam int TID_W = $clog2(N_THR),
  localparam int IDX_W = $clog2(N_SLOT),
  localparam int CNT_W = $clog2(N_SLOT + 1)
) (
  input  logic                         mode_fg_i,
  input  logic [N_THR-1:0][TID_W-1:0]  ord_i,
  input  logic [N_THR-1:0][CNT_W-1:0]  eff_i,
  output logic [N_SLOT-1:0]            slot_vld_o,
  output logic [N_SLOT-1:0][TID_W-1:0] slot_tid_o,
  output logic [N_SLOT-1:0][IDX_W-1:0] slot_idx_o,
  output logic [CNT_W-1:0]             used_o,
  output logic [N_THR-1:0]             grant_o
);
  always_comb begin
    int used;
    int take;
    int sel;
    slot_vld_o = '0;
    slot_tid_o = '0;
    slot_idx_o = '0;
    grant_o    = '0;
    used       = 0;
    sel        = -1;
    if (mode_fg_i) begin
      for (int k = 0; k < N_THR; k++) begin
        if ((sel < 0) && (eff_i[ord_i[k]] != '0)) sel = k;
      end
    end
    for (int k = 0; k < N_THR; k++) begin
      take = int'(eff_i[ord_i[k]]);
      if (mode_fg_i && (k != sel)) take = 0;
      if (take > (N_SLOT - used)) take = N_SLOT - used;
      for (int s = 0; s < N_SLOT; s++) begin
        if ((s >= used) && (s < used + take)) begin
          slot_vld_o[s] = 1'b1;
          slot_tid_o[s] = ord_i[k];
          slot_idx_o[s] = IDX_W'(s - used);
        end
      end
      if (take > 0) grant_o[ord_i[k]] = 1'b1;
      used = used + take;
    end
    used_o = CNT_W'(used);
  end
endmodule

// File: rtl/smt_slot_alloc.sv
module smt_slot_alloc #(
  parameter int NUM_THREADS = 4,
  parameter int NUM_SLOTS   = 4,
  localparam int TID_W = $clog2(NUM_THREADS),
  localparam int IDX_W = $clog2(NUM_SLOTS),
  localparam int CNT_W = $clog2(NUM_SLOTS + 1)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              mode_i,
  input  logic                              prio_en_i,
  input  logic [TID_W-1:0]                  prio_tid_i,
  input  logic [NUM_THREADS-1:0]            req_valid_i,
  input  logic [NUM_THREADS-1:0]            req_stall_i,
  input  logic [NUM_THREADS-1:0][CNT_W-1:0] req_cnt_i,
  output logic [NUM_SLOTS-1:0]              slot_vld_o,
  output logic [NUM_SLOTS-1:0][TID_W-1:0]   slot_tid_o,
  output logic [NUM_SLOTS-1:0][IDX_W-1:0]   slot_idx_o,
  output logic [CNT_W-1:0]                  used_cnt_o,
  output logic [NUM_THREADS-1:0]            thread_rdy_o
);
  import smt_alloc_pkg::*;

  logic [TID_W-1:0]                  ptr;
  logic [NUM_THREADS-1:0][TID_W-1:0] ord;
  logic [NUM_THREADS-1:0][CNT_W-1:0] eff;

  // effective count: zero when idle or stalled, clamped to the slot count
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_eff
    always_comb begin
      if (!req_valid_i[t] || req_stall_i[t])        eff[t] = '0;
      else if (req_cnt_i[t] > CNT_W'(NUM_SLOTS))    eff[t] = CNT_W'(NUM_SLOTS);
      else                                          eff[t] = req_cnt_i[t];
    end
  end

  smt_rr_ptr #(.N_THR(NUM_THREADS)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ptr_o  (ptr)
  );

  smt_thread_order #(.N_THR(NUM_THREADS)) u_order (
    .ptr_i      (ptr),
    .prio_en_i  (prio_en_i),
    .prio_tid_i (prio_tid_i),
    .ord_o      (ord)
  );

  smt_slot_fill #(.N_THR(NUM_THREADS), .N_SLOT(NUM_SLOTS)) u_fill (
    .mode_fg_i  (mode_i == MODE_FGMT),
    .ord_i      (ord),
    .eff_i      (eff),
    .slot_vld_o (slot_vld_o),
    .slot_tid_o (slot_tid_o),
    .slot_idx_o (slot_idx_o),
    .used_o     (used_cnt_o),
    .grant_o    (thread_rdy_o)
  );
endmodule

// File: rtl/smt_slot_alloc_chk.sv
module smt_slot_alloc_chk #(
  parameter int NUM_THREADS = 4,
  parameter int NUM_SLOTS   = 4,
  localparam int TID_W = $clog2(NUM_THREADS),
  localparam int IDX_W = $clog2(NUM_SLOTS),
  localparam int CNT_W = $clog2(NUM_SLOTS + 1)
) (
  input logic                              clk_i,
  input logic                              rst_ni,
  input logic                              mode_i,
  input logic [NUM_THREADS-1:0]            req_valid_i,
  input logic [NUM_THREADS-1:0]            req_stall_i,
  input logic [NUM_SLOTS-1:0]              slot_vld_o,
  input logic [NUM_SLOTS-1:0][TID_W-1:0]   slot_tid_o,
  input logic [NUM_SLOTS-1:0][IDX_W-1:0]   slot_idx_o,
  input logic [CNT_W-1:0]                  used_cnt_o,
  input logic [NUM_THREADS-1:0]            thread_rdy_o
);
  logic [NUM_THREADS-1:0] hit;
  always_comb begin
    hit = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      if (slot_vld_o[s]) hit[slot_tid_o[s]] = 1'b1;
  end

  a_r1_used_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(used_cnt_o) == $countones(slot_vld_o)) && (int'(used_cnt_o) <= NUM_SLOTS));

  a_r10_rdy_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    thread_rdy_o == hit);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    a_r3_no_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
      slot_vld_o[s] |-> (req_valid_i[slot_tid_o[s]] && !req_stall_i[slot_tid_o[s]]));
    a_r2_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !slot_vld_o[s] |-> (slot_tid_o[s] == '0 && slot_idx_o[s] == '0));
    a_r7_single_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i && slot_vld_o[s]) |-> (slot_tid_o[s] == slot_tid_o[0]));
    if (s + 1 < NUM_SLOTS) begin : g_pair
      a_r2_no_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        slot_vld_o[s+1] |-> slot_vld_o[s]);
      a_r4_idx_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        slot_vld_o[s+1] |->
          ((slot_tid_o[s+1] == slot_tid_o[s]) ? (slot_idx_o[s+1] == slot_idx_o[s] + 1'b1)
                                              : (slot_idx_o[s+1] == '0)));
    end
  end
endmodule

bind smt_slot_alloc smt_slot_alloc_chk #(
  .NUM_THREADS(NUM_THREADS),
  .NUM_SLOTS  (NUM_SLOTS)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .req_valid_i  (req_valid_i),
  .req_stall_i  (req_stall_i),
  .slot_vld_o   (slot_vld_o),
  .slot_tid_o   (slot_tid_o),
  .slot_idx_o   (slot_idx_o),
  .used_cnt_o   (used_cnt_o),
  .thread_rdy_o (thread_rdy_o)
);

// File: tb/tb_smt_slot_alloc.sv
module tb_smt_slot_alloc;
  localparam int T     = 4;
  localparam int S     = 4;
  localparam int TID_W = 2;
  localparam int IDX_W = 2;
  localparam int CNT_W = 3;

  logic                    clk_i = 1'b0;
  logic                    rst_ni = 1'b0;
  logic                    mode_i = 1'b0;
  logic                    prio_en_i = 1'b0;
  logic [TID_W-1:0]        prio_tid_i = '0;
  logic [T-1:0]            req_valid_i = '0;
  logic [T-1:0]            req_stall_i = '0;
  logic [T-1:0][CNT_W-1:0] req_cnt_i = '0;
  logic [S-1:0]            slot_vld_o;
  logic [S-1:0][TID_W-1:0] slot_tid_o;
  logic [S-1:0][IDX_W-1:0] slot_idx_o;
  logic [CNT_W-1:0]        used_cnt_o;
  logic [T-1:0]            thread_rdy_o;

  smt_slot_alloc #(.NUM_THREADS(T), .NUM_SLOTS(S)) dut (.*);

  always #10 clk_i = ~clk_i;

  int mptr;
  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) mptr <= 0;
    else         mptr <= (mptr + 1) % T;

  int n_chk = 0;
  int n_err = 0;
  logic [S-1:0]            e_vld;
  logic [S-1:0][TID_W-1:0] e_tid;
  logic [S-1:0][IDX_W-1:0] e_idx;
  logic [T-1:0]            e_rdy;
  int                      e_used;

  task automatic build_exp();
    int ord[$];
    int eff[T];
    int used;
    int pick;
    int n;
    if (prio_en_i) ord.push_back(int'(prio_tid_i));
    for (int j = 0; j < T; j++) begin
      int t = (mptr + j) % T;
      if (!(prio_en_i && t == int'(prio_tid_i))) ord.push_back(t);
    end
    for (int t = 0; t < T; t++) begin
      eff[t] = (req_valid_i[t] && !req_stall_i[t]) ? int'(req_cnt_i[t]) : 0;
      if (eff[t] > S) eff[t] = S;
    end
    pick = -1;
    if (mode_i) foreach (ord[k]) if (pick < 0 && eff[ord[k]] > 0) pick = ord[k];
    e_vld = '0; e_tid = '0; e_idx = '0; e_rdy = '0; used = 0;
    foreach (ord[k]) begin
      n = eff[ord[k]];
      if (mode_i && ord[k] != pick) n = 0;
      for (int i = 0; i < n && used < S; i++) begin
        e_vld[used] = 1'b1;
        e_tid[used] = TID_W'(ord[k]);
        e_idx[used] = IDX_W'(i);
        e_rdy[ord[k]] = 1'b1;
        used++;
      end
    end
    e_used = used;
  endtask

  task automatic check(string tag);
    build_exp();
    n_chk++;
    if (slot_vld_o !== e_vld || slot_tid_o !== e_tid || slot_idx_o !== e_idx ||
        used_cnt_o !== CNT_W'(e_used) || thread_rdy_o !== e_rdy) begin
      n_err++;
      $display("FAIL %s: vld=%b tid=%h idx=%h used=%0d rdy=%b, expected vld=%b tid=%h idx=%h used=%0d rdy=%b",
               tag, slot_vld_o, slot_tid_o, slot_idx_o, used_cnt_o, thread_rdy_o,
               e_vld, e_tid, e_idx, e_used, e_rdy);
    end
  endtask

  task automatic drive(logic m, logic pe, int pt, logic [T-1:0] v, logic [T-1:0] st,
                       int c0, int c1, int c2, int c3);
    mode_i = m; prio_en_i = pe; prio_tid_i = TID_W'(pt);
    req_valid_i = v; req_stall_i = st;
    req_cnt_i[0] = CNT_W'(c0); req_cnt_i[1] = CNT_W'(c1);
    req_cnt_i[2] = CNT_W'(c2); req_cnt_i[3] = CNT_W'(c3);
  endtask

  task automatic step(string tag);
    #5;
    check(tag);
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #(64'd20 * 64'd200000);
    n_err++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R6 reset state: pointer at thread 0
    drive(0, 0, 0, 4'hF, 4'h0, 2, 3, 0, 0);
    #5;
    n_chk++;
    if (slot_vld_o !== 4'hF || slot_tid_o !== 8'h50 || slot_idx_o !== 8'h44 ||
        used_cnt_o !== 3'd4 || thread_rdy_o !== 4'b0011) begin
      n_err++;
      $display("FAIL R6 reset: vld=%b tid=%h idx=%h used=%0d rdy=%b, expected vld=1111 tid=50 idx=44 used=4 rdy=0011",
               slot_vld_o, slot_tid_o, slot_idx_o, used_cnt_o, thread_rdy_o);
    end
    check("R6 reset");
    @(negedge clk_i);
    step("R6 advance");                                 // pointer now 1
    drive(0, 0, 0, 4'hF, 4'h0, 4, 4, 4, 4); step("R1 oversubscribed");
    drive(0, 0, 0, 4'hF, 4'h8, 2, 2, 2, 2); step("R3 stalled thread");
    drive(0, 0, 0, 4'hE, 4'h0, 3, 1, 1, 1); step("R3 invalid thread");
    drive(0, 1, 3, 4'hF, 4'h0, 1, 1, 1, 1); step("R5 priority first");
    drive(0, 1, 2, 4'hF, 4'h4, 2, 2, 4, 2); step("R5 priority stalled");
    drive(1, 0, 0, 4'hF, 4'h0, 0, 3, 2, 1); step("R7 fine-grained");
    drive(1, 0, 0, 4'hF, 4'h0, 0, 0, 0, 2); step("R7 skip empty");
    drive(1, 1, 2, 4'hF, 4'h0, 4, 4, 1, 4); step("R8 priority fine-grained");
    drive(0, 0, 0, 4'h4, 4'h0, 0, 0, 7, 0); step("R9 clamp");
    drive(1, 0, 0, 4'h2, 4'h0, 0, 6, 0, 0); step("R9 clamp fine-grained");
    drive(0, 0, 0, 4'hF, 4'h0, 0, 0, 0, 0); step("R2 all idle");
    drive(0, 0, 0, 4'hF, 4'h0, 1, 0, 2, 0); step("R10 ready per thread");
    for (int i = 0; i < 400; i++) begin
      logic m  = 1'($urandom_range(0, 1));
      logic pe = ($urandom_range(0, 2) == 0);
      drive(m, pe, int'($urandom_range(0, T - 1)), 4'($urandom), 4'($urandom & $urandom),
            int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
            int'($urandom_range(0, 7)), int'($urandom_range(0, 7)));
      step(m ? (pe ? "R8 random" : "R7 random") : (pe ? "R5 random" : "R4 random"));
    end
    finish_run();
  end
endmodule